// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block hands out a pool of equal-sized buffer pages as numbered packets. A host issues an allocate command that carries a byte count. The allocator converts that count into a page count, adding room for a small header, and then walks the pool one page per cycle. It looks for the lowest-addressed contiguous run of free pages that is long enough. When the walk ends, the block writes a packet number, or a failure marker, into a result register and raises a completion flag. The flag can be polled. It also drives an interrupt line when the host has enabled it.

Pages return to the pool through a release command that names a packet number. A reset command clears the whole pool at once and aborts any walk in progress. While a walk is running the block reports itself busy and drops allocate and release commands. Only the reset command is still honoured during a walk.

Top module: `pkt_page_alloc`

## Requirements
- R1: An allocate command with byte count N reserves ceil((N+6)/256) pages as one contiguous run. The run is the lowest-addressed free run that is long enough.
- R2: The result register is 8 bits wide. Bit 7 is the failure flag, bits 6:5 read zero and bits 4:0 hold the packet number. A success assigns the lowest packet number not currently held.
- R3: `alloc_done` rises when an allocation finishes, whether it succeeds or fails. It clears on the edge that accepts a new allocate command. `irq` is high exactly when `alloc_done` and `irq_mask` are both high.
- R4: `busy` is high from the edge that accepts an allocate until the edge that finishes it. A success whose run ends at page e sets `alloc_done` e+1 cycles after the accepting edge. A failure sets it 16 cycles after that edge.
- R5: When no free run is long enough, including requests for more than 16 pages, the result reads 0x80 and no page changes state.
- R6: A release of a held packet number frees all of its pages. The number and the pages can then be allocated again.
- R7: A release of a packet number that is not held leaves every page and packet record unchanged.
- R8: A reset command frees all pages and packet numbers and clears `alloc_done` and the result register on the next edge. It is accepted even while `busy` is high, and it ends the walk.
- R9: Allocate and release commands that arrive while `busy` is high are ignored.
- R10: After `rst_n` is asserted, `busy`, `alloc_done`, `alloc_result` and `irq` all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Command code: 1 allocate, 2 release, 3 reset, 0 none |
| cmd_bytes | input | 13 | Byte count for an allocate |
| cmd_pkt | input | 5 | Packet number for a release |
| irq_mask | input | 1 | Enables the interrupt output |
| busy | output | 1 | A page walk is in progress |
| alloc_done | output | 1 | Allocation-finished status flag |
| alloc_result | output | 8 | Failure flag in bit 7, packet number in bits 4:0 |
| irq | output | 1 | Completion interrupt, gated by the mask |

## Verification
Two functions can land in the same cycle: a page walk that is still running and a new command. The bench sends release and allocate commands during a walk that spans the whole pool. It then shows that the released packet still holds its page, because a following one-page request fails. It also cuts a walk short with a reset command. After that it checks that the walk leaves no trace, and that the next one-page request lands on page 0 as packet 0. A random phase fires commands on any cycle against a behavioural model that is compared on every clock.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_ALLOC   = 2'd1,
        OP_RELEASE = 2'd2,
        OP_RESET   = 2'd3
    } pa_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } pa_state_e;

    localparam int RES_W    = 8;
    localparam int FAIL_BIT = 7;
endpackage

// File: rtl/pa_size_calc.sv
module pa_size_calc #(
    parameter int BYTES_W    = 13,
    parameter int PAGE_BYTES = 256,
    parameter int OVERHEAD   = 6,
    localparam int NEED_W    = BYTES_W + 1
) (
    input  logic [BYTES_W-1:0] bytes_i,
    output logic [NEED_W-1:0]  pages_o
);
    localparam int SH    = $clog2(PAGE_BYTES);
    localparam int SUM_W = BYTES_W + 2;

    logic [SUM_W-1:0] sum_d;

    // round up after adding the header room
    always_comb begin
        sum_d   = SUM_W'(bytes_i) + SUM_W'(OVERHEAD + PAGE_BYTES - 1);
        pages_o = NEED_W'(sum_d >> SH);
    end
endmodule

// File: rtl/pa_page_map.sv
module pa_page_map #(
    parameter int PAGES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [PAGES-1:0] set_mask_i,
    input  logic [PAGES-1:0] clr_mask_i,
    output logic [PAGES-1:0] used_o
);
    logic [PAGES-1:0] used_d, used_q;

    always_comb begin
        if (clear_i) used_d = '0;
        else         used_d = (used_q | set_mask_i) & ~clr_mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) used_q <= '0;
        else        used_q <= used_d;
    end

    assign used_o = used_q;

    // R1
    no_double_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_mask_i) |-> ((set_mask_i & used_q) == '0));

    // R6
    free_only_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask_i) |-> ((clr_mask_i & ~used_q) == '0));
endmodule

// File: rtl/pa_pkt_table.sv
module pa_pkt_table #(
    parameter int PKT_W = 5,
    parameter int IDX_W = 4,
    parameter int LEN_W = 5,
    localparam int NPKT = 1 << PKT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             wr_en_i,
    input  logic [PKT_W-1:0] wr_pkt_i,
    input  logic [IDX_W-1:0] wr_start_i,
    input  logic [LEN_W-1:0] wr_len_i,
    input  logic             inv_en_i,
    input  logic [PKT_W-1:0] inv_pkt_i,
    input  logic [PKT_W-1:0] rd_pkt_i,
    output logic             rd_valid_o,
    output logic [IDX_W-1:0] rd_start_o,
    output logic [LEN_W-1:0] rd_len_o,
    output logic             free_found_o,
    output logic [PKT_W-1:0] free_pkt_o,
    output logic [NPKT-1:0]  valid_o
);
    typedef struct packed {
        logic [NPKT-1:0]             valid;
        logic [NPKT-1:0][IDX_W-1:0] start;
        logic [NPKT-1:0][LEN_W-1:0] len;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clear_i) begin
            t_d.valid = '0;
        end else begin
            if (wr_en_i) begin
                t_d.valid[wr_pkt_i] = 1'b1;
                t_d.start[wr_pkt_i] = wr_start_i;
                t_d.len[wr_pkt_i]   = wr_len_i;
            end
            if (inv_en_i) t_d.valid[inv_pkt_i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // lowest number not currently held
    always_comb begin
        free_found_o = 1'b0;
        free_pkt_o   = '0;
        for (int i = NPKT - 1; i >= 0; i--) begin
            if (!t_q.valid[i]) begin
                free_found_o = 1'b1;
                free_pkt_o   = PKT_W'(i);
            end
        end
    end

    assign rd_valid_o = t_q.valid[rd_pkt_i];
    assign rd_start_o = t_q.start[rd_pkt_i];
    assign rd_len_o   = t_q.len[rd_pkt_i];
    assign valid_o    = t_q.valid;

    // R2
    no_pkt_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> !t_q.valid[wr_pkt_i]);

    // R7
    inv_only_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en_i |-> t_q.valid[inv_pkt_i]);
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
    import pa_pkg::*;
#(
    parameter int PAGES      = 16,
    parameter int PAGE_BYTES = 256,
    parameter int OVERHEAD   = 6,
    parameter int BYTES_W    = 13,
    parameter int PKT_W      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [BYTES_W-1:0] cmd_bytes,
    input  logic [PKT_W-1:0]   cmd_pkt,
    input  logic               irq_mask,
    output logic               busy,
    output logic               alloc_done,
    output logic [7:0]         alloc_result,
    output logic               irq
);
    localparam int IDX_W  = $clog2(PAGES);
    localparam int LEN_W  = $clog2(PAGES + 1);
    localparam int NEED_W = BYTES_W + 1;
    localparam int NPKT   = 1 << PKT_W;
    localparam logic [RES_W-1:0] RES_FAIL = RES_W'(1) << FAIL_BIT;

    typedef struct packed {
        pa_state_e        st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] run_start;
        logic [NEED_W-1:0] run_len;
        logic [NEED_W-1:0] need;
        logic             done;
        logic [RES_W-1:0] result;
    } ctl_t;

    ctl_t c_d, c_q;

    pa_op_e            op;
    logic [NEED_W-1:0] need_w;
    logic [PAGES-1:0]  used;
    logic [PAGES-1:0]  set_mask, clr_mask;
    logic              clear_all, wr_en, inv_en, finish;
    logic              rd_valid, free_found;
    logic [IDX_W-1:0]  rd_start;
    logic [LEN_W-1:0]  rd_len;
    logic [PKT_W-1:0]  free_pkt;
    logic [NPKT-1:0]   pkt_valid;

    function automatic logic [PAGES-1:0] span(input logic [IDX_W-1:0] s,
                                              input logic [NEED_W-1:0] n);
        logic [PAGES-1:0] m;
        for (int i = 0; i < PAGES; i++)
            m[i] = (i >= int'(s)) && (i < int'(s) + int'(n));
        return m;
    endfunction

    pa_size_calc #(.BYTES_W(BYTES_W), .PAGE_BYTES(PAGE_BYTES), .OVERHEAD(OVERHEAD)) u_size (
        .bytes_i (cmd_bytes),
        .pages_o (need_w)
    );

    pa_page_map #(.PAGES(PAGES)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_all),
        .set_mask_i (set_mask),
        .clr_mask_i (clr_mask),
        .used_o     (used)
    );

    pa_pkt_table #(.PKT_W(PKT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_tbl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_all),
        .wr_en_i      (wr_en),
        .wr_pkt_i     (free_pkt),
        .wr_start_i   (c_q.run_start),
        .wr_len_i     (LEN_W'(c_q.need)),
        .inv_en_i     (inv_en),
        .inv_pkt_i    (cmd_pkt),
        .rd_pkt_i     (cmd_pkt),
        .rd_valid_o   (rd_valid),
        .rd_start_o   (rd_start),
        .rd_len_o     (rd_len),
        .free_found_o (free_found),
        .free_pkt_o   (free_pkt),
        .valid_o      (pkt_valid)
    );

    always_comb begin
        c_d       = c_q;
        op        = pa_op_e'(cmd_op);
        clear_all = 1'b0;
        set_mask  = '0;
        clr_mask  = '0;
        wr_en     = 1'b0;
        inv_en    = 1'b0;
        finish    = 1'b0;
        if (cmd_valid && op == OP_RESET) begin
            clear_all   = 1'b1;
            c_d.st      = ST_IDLE;
            c_d.done    = 1'b0;
            c_d.result  = '0;
            c_d.idx     = '0;
            c_d.run_len = '0;
        end else if (c_q.st == ST_IDLE) begin
            if (cmd_valid && op == OP_ALLOC) begin
                c_d.st        = ST_SCAN;
                c_d.need      = need_w;
                c_d.idx       = '0;
                c_d.run_start = '0;
                c_d.run_len   = '0;
                c_d.done      = 1'b0;
            end else if (cmd_valid && op == OP_RELEASE && rd_valid) begin
                clr_mask = span(rd_start, NEED_W'(rd_len));
                inv_en   = 1'b1;
            end
        end else begin
            if (!used[c_q.idx]) begin
                if (c_q.run_len + NEED_W'(1) == c_q.need) begin
                    finish = 1'b1;
                    if (free_found) begin
                        set_mask   = span(c_q.run_start, c_q.need);
                        wr_en      = 1'b1;
                        c_d.result = RES_W'(free_pkt);
                    end else begin
                        c_d.result = RES_FAIL;
                    end
                end else begin
                    c_d.run_len = c_q.run_len + NEED_W'(1);
                end
            end else begin
                c_d.run_len   = '0;
                c_d.run_start = c_q.idx + IDX_W'(1);
            end
            if (!finish && c_q.idx == IDX_W'(PAGES - 1)) begin
                finish     = 1'b1;
                c_d.result = RES_FAIL;
            end else if (!finish) begin
                c_d.idx = c_q.idx + IDX_W'(1);
            end
            if (finish) begin
                c_d.st   = ST_IDLE;
                c_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy         = (c_q.st == ST_SCAN);
    assign alloc_done   = c_q.done;
    assign alloc_result = c_q.result;
    assign irq          = c_q.done & irq_mask;

    // R3
    done_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.done) |-> $past(c_q.st) == ST_SCAN);

    // R5
    fail_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(c_q.done) && c_q.result[FAIL_BIT]) |-> used == $past(used));

    // R2
    success_owns_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(c_q.done) && !c_q.result[FAIL_BIT]) |-> pkt_valid[c_q.result[PKT_W-1:0]]);

    // R8
    reset_cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3) |=> (used == '0 && !c_q.done && c_q.st == ST_IDLE));

    // R9
    busy_release_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_SCAN && cmd_valid && cmd_op == 2'd2) |=> (($past(used) & ~used) == '0));
endmodule

// File: tb/sim_pkt_page_alloc.sv
module sim_pkt_page_alloc;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;
    localparam int NK = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [12:0] cmd_bytes = '0;
    logic [4:0]  cmd_pkt = '0;
    logic        irq_mask = 1'b0;
    logic        busy, alloc_done, irq;
    logic [7:0]  alloc_result;

    int checks = 0;
    int errors = 0;
    bit model_live = 0;

    // behavioural model state
    int m_used[NP];
    int m_pv[NK];
    int m_ps[NK];
    int m_pl[NK];
    int m_cnt, m_done, m_res;
    int p_ok, p_pkt, p_s, p_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_page_alloc u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bytes(cmd_bytes), .cmd_pkt(cmd_pkt), .irq_mask(irq_mask),
        .busy(busy), .alloc_done(alloc_done), .alloc_result(alloc_result), .irq(irq)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NP; i++) m_used[i] = 0;
        for (int k = 0; k < NK; k++) m_pv[k] = 0;
        m_cnt = 0; m_done = 0; m_res = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
            model_live = 1;
        end else if (cmd_valid && cmd_op == 2'd3) begin
            model_clear();
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                if (p_ok != 0) begin
                    for (int i = p_s; i < p_s + p_n; i++) m_used[i] = 1;
                    m_pv[p_pkt] = 1; m_ps[p_pkt] = p_s; m_pl[p_pkt] = p_n;
                    m_res = p_pkt;
                end else begin
                    m_res = 8'h80;
                end
                m_done = 1;
            end
        end else if (cmd_valid && cmd_op == 2'd1) begin
            int need, s, fk;
            need = (int'(cmd_bytes) + 6 + 255) / 256;
            s = -1;
            for (int c = 0; c + need <= NP && s < 0; c++) begin
                bool_free: begin
                    int ok;
                    ok = 1;
                    for (int j = c; j < c + need; j++) if (m_used[j] != 0) ok = 0;
                    if (ok != 0) s = c;
                end
            end
            fk = -1;
            for (int k = NK - 1; k >= 0; k--) if (m_pv[k] == 0) fk = k;
            m_done = 0;
            if (s >= 0) begin
                m_cnt = s + need;
                p_ok = (fk >= 0) ? 1 : 0; p_pkt = fk; p_s = s; p_n = need;
            end else begin
                m_cnt = NP; p_ok = 0;
            end
        end else if (cmd_valid && cmd_op == 2'd2) begin
            if (m_pv[cmd_pkt] != 0) begin
                for (int i = m_ps[cmd_pkt]; i < m_ps[cmd_pkt] + m_pl[cmd_pkt]; i++) m_used[i] = 0;
                m_pv[cmd_pkt] = 0;
            end
        end
    end

    // compare with the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && model_live) begin
            chk(int'(busy), (m_cnt > 0) ? 1 : 0, "R4 busy");
            chk(int'(alloc_done), m_done, "R3 done");
            chk(int'(alloc_result), m_res, "R2 result");
            chk(int'(irq), m_done & int'(irq_mask), "R3 irq");
        end
    end

    task automatic send(input logic [1:0] op, input int bytes, input int pkt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bytes = 13'(bytes); cmd_pkt = 5'(pkt);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic do_alloc(input int bytes, output int lat, output int res);
        send(2'd1, bytes, 0);
        lat = 0;
        while (!alloc_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        res = int'(alloc_result);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat, res;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(int'(busy), 0, "R10 busy");
        chk(int'(alloc_done), 0, "R10 done");
        chk(int'(alloc_result), 0, "R10 result");
        chk(int'(irq), 0, "R10 irq");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: 250 bytes fit one page
        do_alloc(250, lat, res);
        chk(res, 8'h00, "R1 one page pkt");
        chk(lat, 1, "R4 latency page0");
        // R1: 251 bytes need two pages, run pages 1..2
        do_alloc(251, lat, res);
        chk(res, 8'h01, "R1 two page pkt");
        chk(lat, 3, "R4 latency end page2");

        // R6 release, R7 repeat and unheld releases ignored
        send(2'd2, 0, 1);
        send(2'd2, 0, 1);
        send(2'd2, 0, 9);
        do_alloc(500, lat, res);
        chk(res, 8'h01, "R6 reuse pkt");
        chk(lat, 3, "R6 reuse pages 1..2");

        // R5 failures
        do_alloc(4000, lat, res);
        chk(res, 8'h80, "R5 too few pages");
        chk(lat, 16, "R4 fail latency");
        do_alloc(8000, lat, res);
        chk(res, 8'h80, "R5 over pool size");

        // R3 interrupt mask
        irq_mask = 1'b1;
        @(negedge clk);
        chk(int'(irq), 1, "R3 irq enabled");
        send(2'd1, 0, 0);
        chk(int'(alloc_done), 0, "R3 cleared on accept");
        lat = 0;
        while (!alloc_done && lat < 40) begin @(negedge clk); lat++; end
        chk(int'(alloc_result), 8'h02, "R2 page3 pkt2");
        chk(int'(irq), 1, "R3 irq on done");
        irq_mask = 1'b0;
        @(negedge clk);
        chk(int'(irq), 0, "R3 irq masked");

        // R9 commands during a walk
        send(2'd1, 3000, 0);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_pkt = 5'd0;
        @(negedge clk);
        cmd_op = 2'd1; cmd_bytes = 13'd0;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
        lat = 2;
        while (!alloc_done && lat < 40) begin @(negedge clk); lat++; end
        chk(lat, 16, "R9 walk undisturbed");
        chk(int'(alloc_result), 8'h03, "R9 pkt3");
        do_alloc(0, lat, res);
        chk(res, 8'h80, "R9 release ignored pool full");

        // R8 reset command
        send(2'd3, 0, 0);
        chk(int'(alloc_done), 0, "R8 done cleared");
        chk(int'(alloc_result), 0, "R8 result cleared");
        do_alloc(3850, lat, res);
        chk(res, 8'h00, "R8 whole pool free");
        chk(lat, 16, "R8 full run latency");

        // R8 reset during a walk
        send(2'd3, 0, 0);
        send(2'd1, 3850, 0);
        repeat (4) @(negedge clk);
        chk(int'(busy), 1, "R8 walking");
        send(2'd3, 0, 0);
        chk(int'(busy), 0, "R8 walk aborted");
        chk(int'(alloc_done), 0, "R8 no done");
        do_alloc(100, lat, res);
        chk(res, 8'h00, "R8 page0 pkt0");
        chk(lat, 1, "R8 page0 latency");

        // random commands on any cycle
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            cmd_valid = ($urandom % 3) == 0;
            case ($urandom % 16)
                0:       cmd_op = 2'd3;
                1,2,3,4,5,6: cmd_op = 2'd2;
                default: cmd_op = 2'd1;
            endcase
            cmd_bytes = 13'($urandom % 4500);
            cmd_pkt   = 5'($urandom % 8);
            irq_mask  = 1'($urandom);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule